// File: doc/BRIEF.md
# Restart-Vector Interrupt Acknowledge Unit

This unit sits next to an 8-bit processor that has a single interrupt request input. It gives that processor one global interrupt-enable flag, which decoded enable and disable strobes set and clear. It latches requests from up to eight devices and merges them onto one request line. A fixed priority picks which device is served first.

When the processor runs its acknowledge cycle, the unit places a one-byte restart instruction on the data bus. The acknowledge cycle is timed like a memory read, and the acknowledge input stays high for one or more clocks. The restart instruction for source n is `0xC7 | (n << 3)`, so source 7 gives `0xFF`. The unit also reports the jump target for that restart, which is n times 8.

Accepting a request clears the enable flag. The processor therefore takes only one event until software enables interrupts again.

Top module: `rstv_ack_unit`

## Requirements
- R1: While reset is asserted and after it is released, `int_req` is 0, `data_oe` is 0, `data_o` is 0x00, the enable flag is clear and no source is pending.
- R2: A high `en_stb` sets the enable flag and a high `dis_stb` clears it; when both are high in the same cycle, the flag is cleared. `int_req` is high exactly when the flag is set and at least one source is pending.
- R3: The rising edge of `ack` (high now, low in the previous cycle) clears the enable flag. `int_req` is low from the next cycle until the next `en_stb`.
- R4: A source becomes pending only on a 0-to-1 transition of its `dev_req` bit, seen at a clock edge. Holding the bit high after it has been served does not make it pending again.
- R5: Among pending sources, the lowest index wins.
- R6: While `ack` is high, `data_oe` is 1 and `data_o` carries `0xC7 | (n << 3)` for the winning index n; this value stays stable for the whole acknowledge. While `ack` is low, `data_oe` is 0 and `data_o` is 0x00.
- R7: `vec_addr` equals n*8, zero-extended. During an acknowledge, n is the source being served; otherwise n is the current winner.
- R8: The served source's pending flag is cleared at the rising edge of `ack`.
- R9: An acknowledge with nothing pending answers with restart 7: `data_o` is 0xFF and `vec_addr` is 0x0038.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_stb | input | 1 | Decoded interrupt-enable instruction strobe |
| dis_stb | input | 1 | Decoded interrupt-disable instruction strobe |
| dev_req | input | NUM_SRC | Device request inputs; bit 0 has the highest priority |
| ack | input | 1 | Interrupt acknowledge from the processor, active high |
| int_req | output | 1 | Merged interrupt request to the processor |
| data_o | output | 8 | Restart opcode for the data bus |
| data_oe | output | 1 | Data bus output enable |
| vec_addr | output | ADDR_W | Jump target of the selected restart |

## Verification
A wrong pending flag or enable flag shows up at the ports within one cycle. It appears as a wrong `int_req` level right after an enable strobe, or as a wrong opcode or vector at the next acknowledge. A stale pending bit shows up as an extra request once the expected sources are all served and enable is set again. A wrong priority shows up as the wrong opcode on the bus in the first cycle of the acknowledge. The sweep covers every combination of the eight sources, so each ordering is checked one service at a time.

// File: rtl/rstv_pkg.sv
package rstv_pkg;
  localparam int unsigned IDX_W       = 3;
  localparam int unsigned SLOT_SHIFT  = 3;
  localparam logic [7:0]  RST_BASE    = 8'hC7;
  localparam logic [IDX_W-1:0] IDLE_IDX = 3'd7;

  function automatic logic [7:0] rst_opcode(input logic [IDX_W-1:0] n);
    return RST_BASE | {2'b00, n, 3'b000};
  endfunction
endpackage

// File: rtl/rstv_pending.sv
module rstv_pending #(
  parameter int unsigned N = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [N-1:0]               req,
  input  logic                       clr_en,
  input  logic [rstv_pkg::IDX_W-1:0] clr_idx,
  output logic [N-1:0]               pend
);
  logic [N-1:0] req_q;
  logic [N-1:0] pend_nx;

  for (genvar g = 0; g < N; g++) begin : g_src
    logic clr_hit;
    assign clr_hit    = clr_en && (clr_idx == rstv_pkg::IDX_W'(g));
    assign pend_nx[g] = (pend[g] && !clr_hit) || (req[g] && !req_q[g]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= '0;
      pend  <= '0;
    end else begin
      req_q <= req;
      pend  <= pend_nx;
    end
  end
endmodule

// File: rtl/rstv_prio.sv
module rstv_prio #(
  parameter int unsigned N = 8
) (
  input  logic [N-1:0]               pend,
  output logic                       any,
  output logic [rstv_pkg::IDX_W-1:0] idx
);
  always_comb begin
    any = |pend;
    idx = rstv_pkg::IDLE_IDX;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend[i]) idx = rstv_pkg::IDX_W'(i);
    end
  end
endmodule

// File: rtl/rstv_enable.sv
module rstv_enable (
  input  logic clk,
  input  logic rst_n,
  input  logic set_stb,
  input  logic clr_stb,
  input  logic accept,
  output logic ie
);
  logic ie_nx;

  always_comb begin
    ie_nx = ie;
    if (set_stb) ie_nx = 1'b1;
    if (clr_stb) ie_nx = 1'b0;
    if (accept)  ie_nx = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ie <= 1'b0;
    else        ie <= ie_nx;
  end
endmodule

// File: rtl/rstv_ack_unit.sv
module rstv_ack_unit #(
  parameter int unsigned NUM_SRC = 8,
  parameter int unsigned ADDR_W  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en_stb,
  input  logic               dis_stb,
  input  logic [NUM_SRC-1:0] dev_req,
  input  logic               ack,
  output logic               int_req,
  output logic [7:0]         data_o,
  output logic               data_oe,
  output logic [ADDR_W-1:0]  vec_addr
);
  import rstv_pkg::*;

  localparam int unsigned VEC_W = IDX_W + SLOT_SHIFT;

  logic [NUM_SRC-1:0] pend;
  logic               any_pend;
  logic [IDX_W-1:0]   win_idx;
  logic               ie;
  logic               ack_q;
  logic               ack_rise;
  logic [IDX_W-1:0]   sel_q;
  logic [IDX_W-1:0]   sel_nx;
  logic [IDX_W-1:0]   cur_idx;

  assign ack_rise = ack && !ack_q;

  rstv_pending #(.N(NUM_SRC)) u_pend (
    .clk(clk), .rst_n(rst_n), .req(dev_req),
    .clr_en(ack_rise), .clr_idx(win_idx), .pend(pend)
  );

  rstv_prio #(.N(NUM_SRC)) u_prio (
    .pend(pend), .any(any_pend), .idx(win_idx)
  );

  rstv_enable u_en (
    .clk(clk), .rst_n(rst_n), .set_stb(en_stb), .clr_stb(dis_stb),
    .accept(ack_rise), .ie(ie)
  );

  always_comb begin
    sel_nx = sel_q;
    if (ack_rise) sel_nx = win_idx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q <= 1'b0;
      sel_q <= IDLE_IDX;
    end else begin
      ack_q <= ack;
      sel_q <= sel_nx;
    end
  end

  assign cur_idx  = (ack && ack_q) ? sel_q : win_idx;
  assign int_req  = ie && any_pend;
  assign data_oe  = ack;
  assign data_o   = ack ? rst_opcode(cur_idx) : 8'h00;
  assign vec_addr = ADDR_W'({cur_idx, {SLOT_SHIFT{1'b0}}});

  logic [VEC_W-1:0] unused_w;
  assign unused_w = '0;
endmodule

// File: rtl/rstv_ack_chk.sv
module rstv_ack_chk #(
  parameter int unsigned ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dis_stb,
  input logic              ack,
  input logic              int_req,
  input logic [7:0]        data_o,
  input logic              data_oe,
  input logic [ADDR_W-1:0] vec_addr
);
  // R3
  accept_clears_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack) |=> !int_req);

  // R2
  disable_drops_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(dis_stb) |-> !int_req);

  // R6
  opcode_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe |-> (data_o[7:6] == 2'b11 && data_o[2:0] == 3'b111));

  // R6
  opcode_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && $past(ack)) |-> $stable(data_o));

  // R7
  vector_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe |-> (vec_addr == ADDR_W'({data_o[5:3], 3'b000})));

  // R1
  idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !data_oe |-> (data_o == 8'h00));
endmodule

bind rstv_ack_unit rstv_ack_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .dis_stb(dis_stb), .ack(ack),
  .int_req(int_req), .data_o(data_o), .data_oe(data_oe), .vec_addr(vec_addr)
);

// File: tb/test_rstv_ack_unit.sv
`timescale 1ns/1ps
module test_rstv_ack_unit;
  localparam int NS = 8;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          en_stb = 1'b0;
  logic          dis_stb = 1'b0;
  logic [NS-1:0] dev_req = '0;
  logic          ack = 1'b0;
  logic          int_req;
  logic [7:0]    data_o;
  logic          data_oe;
  logic [AW-1:0] vec_addr;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  rstv_ack_unit #(.NUM_SRC(NS), .ADDR_W(AW)) i_rstv_ack_unit (
    .clk(clk), .rst_n(rst_n), .en_stb(en_stb), .dis_stb(dis_stb),
    .dev_req(dev_req), .ack(ack), .int_req(int_req), .data_o(data_o),
    .data_oe(data_oe), .vec_addr(vec_addr)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic pulse_en();
    en_stb = 1'b1; tick(); en_stb = 1'b0;
  endtask

  task automatic pulse_dis();
    dis_stb = 1'b1; tick(); dis_stb = 1'b0;
  endtask

  // Serve one acknowledge, expecting source n (R6, R7, R3, R9)
  task automatic serve(input int n);
    int op;
    op = 'hC7 | (n << 3);
    ack = 1'b1;
    #1;
    chk(data_oe == 1'b1, "R6 oe", data_oe, 1);
    chk(data_o == op[7:0], "R6 opcode first", data_o, op);
    chk(vec_addr == AW'(n * 8), "R7 vector first", vec_addr, n * 8);
    tick();
    chk(data_o == op[7:0], "R6 opcode held", data_o, op);
    chk(vec_addr == AW'(n * 8), "R7 vector held", vec_addr, n * 8);
    chk(int_req == 1'b0, "R3 enable cleared", int_req, 0);
    tick();
    chk(data_o == op[7:0], "R6 opcode late", data_o, op);
    ack = 1'b0;
    #1;
    chk(data_oe == 1'b0 && data_o == 8'h00, "R6 bus released", data_o, 0);
    tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #2;
    chk(int_req == 1'b0 && data_oe == 1'b0 && data_o == 8'h00, "R1 in reset", int_req, 0);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick();
    chk(int_req == 1'b0 && data_oe == 1'b0, "R1 after reset", int_req, 0);

    // R2: pending but not enabled
    dev_req = 8'h01; tick(); dev_req = '0; tick();
    chk(int_req == 1'b0, "R2 gated by enable", int_req, 0);
    pulse_en();
    chk(int_req == 1'b1, "R2 enable raises request", int_req, 1);
    pulse_dis();
    chk(int_req == 1'b0, "R2 disable drops request", int_req, 0);
    en_stb = 1'b1; dis_stb = 1'b1; tick(); en_stb = 1'b0; dis_stb = 1'b0;
    chk(int_req == 1'b0, "R2 disable wins same cycle", int_req, 0);
    pulse_en();
    serve(0);
    pulse_en();
    chk(int_req == 1'b0, "R8 served source cleared", int_req, 0);
    pulse_dis();

    // R5/R8: sweep every request pattern
    for (int m = 1; m < 256; m++) begin
      int left;
      left = m;
      dev_req = m[NS-1:0]; tick(); dev_req = '0; tick();
      while (left != 0) begin
        int lo;
        lo = 0;
        while (((left >> lo) & 1) == 0) lo++;
        pulse_en();
        chk(int_req == 1'b1, "R2 pending request", int_req, 1);
        chk(vec_addr == AW'(lo * 8), "R5 lowest index wins", vec_addr, lo * 8);
        serve(lo);
        left = left & ~(1 << lo);
      end
      pulse_en();
      chk(int_req == 1'b0, "R8 all served", int_req, 0);
      pulse_dis();
    end

    // R4: a held level does not re-arm after being served
    dev_req = 8'h10; tick(); tick();
    pulse_en();
    serve(4);
    pulse_en();
    chk(int_req == 1'b0, "R4 held level ignored", int_req, 0);
    dev_req = '0; tick();
    dev_req = 8'h10; tick();
    chk(int_req == 1'b1, "R4 new edge re-arms", int_req, 1);
    dev_req = '0;
    serve(4);

    // R9: acknowledge with nothing pending
    chk(vec_addr == AW'(16'h0038), "R9 idle vector", vec_addr, 'h38);
    serve(7);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule